// File: doc/BRIEF.md
# Coprocessor Two-Beat Load/Store Sequencer

This block moves data between a 32-bit memory data path and a coprocessor register file of sixteen 64-bit registers. A transfer is carried out as one or two phases. Each phase is either a non-data phase, which just re-arms the beat counter, or a data phase that carries one 32-bit word. Instruction bit 22 picks a one-word or a two-word transfer. Instruction bits 15:12 pick the register.

During a two-word transfer the block answers the first data beat with an increment-address response and the second with a done response. An endianness input decides whether the first word lands in the upper or the lower half of the register. One-word transfers pick the half by data kind. A floating-point word lives in the upper half. A 32-bit integer lives in the lower half, and an integer load sign-fills the upper half.

Load data is written into the register file on the clock edge that ends the data beat. Store data is driven combinationally during the beat. Address generation and the bus protocol are handled elsewhere.

Top module: `cpx_ldst_seq`

## Requirements
- R1: After reset every register reads as zero, and the first two-word data beat is treated as the first beat.
- R2: A non-data phase (phase_req=1, phase_data=0) answers rsp_done=1 and rsp_inc=0 and leaves every register unchanged.
- R3: A two-word transfer (instruction bit 22 = 1) answers rsp_inc on its first data beat and rsp_done on its second; rsp_inc and rsp_done are never high together.
- R4: With big_endian=1, the first word of a two-word transfer maps to register bits 63:32 and the second to bits 31:0, for both loads and stores.
- R5: With big_endian=0, the first word of a two-word transfer maps to bits 31:0 and the second to bits 63:32, for both loads and stores.
- R6: A one-word transfer with int_mode=0 loads into or stores from bits 63:32 only; a load leaves bits 31:0 unchanged.
- R7: A one-word load with int_mode=1 writes the word into bits 31:0 and copies its bit 31 into all of bits 63:32.
- R8: A one-word store with int_mode=1 drives bits 31:0 of the register on st_word.
- R9: The register is selected by instruction bits 15:12; no other register changes and other instruction bits have no effect.
- R10: With phase_req=0 both responses are low, no register changes, and st_word is zero whenever the phase is not a store data beat.
- R11: A non-data phase presented after the first beat of a two-word transfer clears the beat count, so the next two-word data beat is again a first beat answered with rsp_inc.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_instr | input | 32 | Transfer instruction word (bit 22 width select, bits 15:12 register index) |
| phase_req | input | 1 | A phase is presented this cycle |
| phase_data | input | 1 | 1 = data phase, 0 = non-data phase |
| xfer_store | input | 1 | 1 = store (register to memory), 0 = load |
| int_mode | input | 1 | One-word data kind: 1 = 32-bit integer, 0 = single-precision float |
| big_endian | input | 1 | Word order of two-word transfers |
| ld_word | input | 32 | Load data from memory |
| st_word | output | 32 | Store data to memory |
| rsp_inc | output | 1 | Increment address, another beat follows |
| rsp_done | output | 1 | Transfer complete |

## Verification
The two functions that collide are beat sequencing and the counter clear done by a non-data phase. A non-data phase that arrives while the counter holds one beat must both answer done and decide which half the next two-word beat uses. The bench provokes this by issuing one two-word data beat and then a non-data phase before the second beat. It then starts a fresh two-word load. Both words of that load must land as a first and a second beat, with rsp_inc on the first, and the register is checked by reading it back through stores.

// File: rtl/cpx_ldst_pkg.sv
package cpx_ldst_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned REG_COUNT  = 16;
  localparam int unsigned IDX_LSB    = 12;
  localparam int unsigned WIDE_BIT   = 22;
  localparam int unsigned IDX_W      = $clog2(REG_COUNT);
  localparam int unsigned REG_W      = 2 * WORD_W;

  typedef enum logic [1:0] {
    RESP_NONE = 2'b00,
    RESP_INC  = 2'b01,
    RESP_DONE = 2'b10
  } resp_e;
endpackage

// File: rtl/cpx_beat_ctrl.sv
module cpx_beat_ctrl
  import cpx_ldst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic phase_req,
  input  logic phase_data,
  input  logic wide,
  output logic second_beat,
  output logic rsp_inc,
  output logic rsp_done
);

  logic  second_q;
  logic  second_d;
  logic  cnt_en;
  resp_e resp;

  // next-state and response
  always_comb begin
    cnt_en   = phase_req;
    second_d = 1'b0;
    resp     = RESP_NONE;
    if (phase_req) begin
      if (!phase_data) begin
        second_d = 1'b0;
        resp     = RESP_DONE;
      end else if (wide && !second_q) begin
        second_d = 1'b1;
        resp     = RESP_INC;
      end else begin
        second_d = 1'b0;
        resp     = RESP_DONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_q <= 1'b0;
    end else if (cnt_en) begin
      second_q <= second_d;
    end
  end

  assign second_beat = second_q;
  assign rsp_inc     = (resp == RESP_INC);
  assign rsp_done    = (resp == RESP_DONE);

  AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_inc && rsp_done)); // R3
  AST_INC_ARMS_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_inc |=> second_q); // R3
  AST_NONDATA_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_req && !phase_data) |-> (rsp_done && !rsp_inc)); // R2
  AST_NONDATA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_req && !phase_data) |=> !second_q); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_req |-> (!rsp_inc && !rsp_done)); // R10

endmodule

// File: rtl/cpx_half_sel.sv
module cpx_half_sel
  import cpx_ldst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_req,
  input  logic              phase_data,
  input  logic              xfer_store,
  input  logic              int_mode,
  input  logic              wide,
  input  logic              big_endian,
  input  logic              second_beat,
  input  logic [WORD_W-1:0] ld_word,
  input  logic [REG_W-1:0]  rd_reg,
  output logic              wr_lo_en,
  output logic              wr_hi_en,
  output logic [WORD_W-1:0] wr_lo_data,
  output logic [WORD_W-1:0] wr_hi_data,
  output logic [WORD_W-1:0] st_word
);

  logic data_beat;
  logic sel_hi;

  always_comb begin
    data_beat  = phase_req && phase_data;
    // wide: first beat goes high when big-endian, second beat flips it
    sel_hi     = wide ? (big_endian ^ second_beat) : !int_mode;
    wr_lo_en   = 1'b0;
    wr_hi_en   = 1'b0;
    wr_lo_data = ld_word;
    wr_hi_data = ld_word;
    st_word    = '0;
    if (data_beat) begin
      if (xfer_store) begin
        st_word = sel_hi ? rd_reg[REG_W-1:WORD_W] : rd_reg[WORD_W-1:0];
      end else if (!wide && int_mode) begin
        wr_lo_en   = 1'b1;
        wr_hi_en   = 1'b1;
        wr_hi_data = {WORD_W{ld_word[WORD_W-1]}};
      end else begin
        wr_lo_en = !sel_hi;
        wr_hi_en = sel_hi;
      end
    end
  end

  AST_WIDE_ONE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_req && phase_data && wide) |-> $countones({wr_lo_en, wr_hi_en}) <= 1); // R4
  AST_STORE_ZERO_ELSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(phase_req && phase_data && xfer_store) |-> (st_word == '0)); // R10

endmodule

// File: rtl/cpx_regfile.sv
module cpx_regfile
  import cpx_ldst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_lo_en,
  input  logic              wr_hi_en,
  input  logic [WORD_W-1:0] wr_lo_data,
  input  logic [WORD_W-1:0] wr_hi_data,
  output logic [REG_W-1:0]  rd_reg
);

  logic [REG_W-1:0] reg_q [REG_COUNT];

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    logic             hit;
    logic             lo_en;
    logic             hi_en;
    logic [REG_W-1:0] reg_d;

    always_comb begin
      hit   = (idx == IDX_W'(g));
      lo_en = hit && wr_lo_en;
      hi_en = hit && wr_hi_en;
      reg_d = reg_q[g];
      if (lo_en) reg_d[WORD_W-1:0]     = wr_lo_data;
      if (hi_en) reg_d[REG_W-1:WORD_W] = wr_hi_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[g] <= '0;
      end else if (lo_en || hi_en) begin
        reg_q[g] <= reg_d;
      end
    end
  end

  assign rd_reg = reg_q[idx];

  AST_SEXT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_en && wr_hi_en) |-> (wr_hi_data == {WORD_W{wr_lo_data[WORD_W-1]}})); // R7
  AST_LO_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_en |=> (reg_q[$past(idx)][WORD_W-1:0] == $past(wr_lo_data))); // R9

endmodule

// File: rtl/cpx_ldst_seq.sv
module cpx_ldst_seq
  import cpx_ldst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       xfer_instr,
  input  logic              phase_req,
  input  logic              phase_data,
  input  logic              xfer_store,
  input  logic              int_mode,
  input  logic              big_endian,
  input  logic [WORD_W-1:0] ld_word,
  output logic [WORD_W-1:0] st_word,
  output logic              rsp_inc,
  output logic              rsp_done
);

  logic              wide;
  logic [IDX_W-1:0]  idx;
  logic              second_beat;
  logic              wr_lo_en;
  logic              wr_hi_en;
  logic [WORD_W-1:0] wr_lo_data;
  logic [WORD_W-1:0] wr_hi_data;
  logic [REG_W-1:0]  rd_reg;
  logic              instr_unused;

  assign wide         = xfer_instr[WIDE_BIT];
  assign idx          = xfer_instr[IDX_LSB +: IDX_W];
  assign instr_unused = ^xfer_instr;

  cpx_beat_ctrl i_beat (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_req   (phase_req),
    .phase_data  (phase_data),
    .wide        (wide),
    .second_beat (second_beat),
    .rsp_inc     (rsp_inc),
    .rsp_done    (rsp_done)
  );

  cpx_half_sel i_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_req   (phase_req),
    .phase_data  (phase_data),
    .xfer_store  (xfer_store),
    .int_mode    (int_mode),
    .wide        (wide),
    .big_endian  (big_endian),
    .second_beat (second_beat),
    .ld_word     (ld_word),
    .rd_reg      (rd_reg),
    .wr_lo_en    (wr_lo_en),
    .wr_hi_en    (wr_hi_en),
    .wr_lo_data  (wr_lo_data),
    .wr_hi_data  (wr_hi_data),
    .st_word     (st_word)
  );

  cpx_regfile i_rf (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx        (idx),
    .wr_lo_en   (wr_lo_en),
    .wr_hi_en   (wr_hi_en),
    .wr_lo_data (wr_lo_data),
    .wr_hi_data (wr_hi_data),
    .rd_reg     (rd_reg)
  );

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(phase_req && phase_data) |-> (!wr_lo_en && !wr_hi_en)); // R2
  AST_STORE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_store |-> (!wr_lo_en && !wr_hi_en)); // R8

endmodule

// File: tb/test_cpx_ldst_seq.sv
`timescale 1ns/1ps
module test_cpx_ldst_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] xfer_instr;
  logic        phase_req, phase_data, xfer_store, int_mode, big_endian;
  logic [31:0] ld_word;
  logic [31:0] st_word;
  logic        rsp_inc, rsp_done;

  int n_run  = 0;
  int n_fail = 0;

  logic [31:0] s_st;
  logic        s_inc, s_done;

  always #2 clk = ~clk;

  cpx_ldst_seq i_cpx_ldst_seq (
    .clk(clk), .rst_n(rst_n), .xfer_instr(xfer_instr), .phase_req(phase_req),
    .phase_data(phase_data), .xfer_store(xfer_store), .int_mode(int_mode),
    .big_endian(big_endian), .ld_word(ld_word), .st_word(st_word),
    .rsp_inc(rsp_inc), .rsp_done(rsp_done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_instr(input logic w, input logic [3:0] r);
    logic [31:0] v;
    v = 32'hA5A5_0A5A;
    v[22] = w;
    v[15:12] = r;
    return v;
  endfunction

  // apply one phase at the falling edge, sample before the rising edge
  task automatic phase(input logic rq, input logic dt, input logic st, input logic im,
                       input logic be, input logic [31:0] ins, input logic [31:0] d);
    @(negedge clk);
    phase_req = rq; phase_data = dt; xfer_store = st; int_mode = im;
    big_endian = be; xfer_instr = ins; ld_word = d;
    #1;
    s_st = st_word; s_inc = rsp_inc; s_done = rsp_done;
    @(posedge clk);
    #0.5;
    phase_req = 1'b0; phase_data = 1'b0;
  endtask

  // read a register through two one-word stores: int gives low, float gives high
  task automatic read_reg(input logic [3:0] r, output logic [63:0] v);
    phase(1, 1, 1, 1, 0, mk_instr(0, r), 32'h0);
    v[31:0] = s_st;
    phase(1, 1, 1, 0, 0, mk_instr(0, r), 32'h0);
    v[63:32] = s_st;
  endtask

  task automatic t_reset;
    logic [63:0] v;
    read_reg(4'd5, v);
    chk("R1 reg zero after reset", v, 64'h0);
    phase(1, 1, 0, 0, 1, mk_instr(1, 4'd6), 32'h1111_2222);
    chk("R1 first wide beat inc", {s_inc, s_done}, 2'b10);
    phase(1, 1, 0, 0, 1, mk_instr(1, 4'd6), 32'h3333_4444);
  endtask

  task automatic t_wide(input logic be);
    logic [63:0] v;
    logic [63:0] exp;
    phase(1, 0, 0, 0, be, mk_instr(1, 4'd3), 32'h0);
    phase(1, 1, 0, 0, be, mk_instr(1, 4'd3), 32'hAAAA_0001);
    chk("R3 first beat INC", {s_inc, s_done}, 2'b10);
    phase(1, 1, 0, 0, be, mk_instr(1, 4'd3), 32'hBBBB_0002);
    chk("R3 second beat DONE", {s_inc, s_done}, 2'b01);
    read_reg(4'd3, v);
    exp = be ? 64'hAAAA_0001_BBBB_0002 : 64'hBBBB_0002_AAAA_0001;
    chk(be ? "R4 wide load order" : "R5 wide load order", v, exp);
    phase(1, 0, 1, 0, be, mk_instr(1, 4'd3), 32'h0);
    phase(1, 1, 1, 0, be, mk_instr(1, 4'd3), 32'h0);
    chk(be ? "R4 wide store first" : "R5 wide store first", s_st,
        be ? 32'hAAAA_0001 : 32'hAAAA_0001);
    phase(1, 1, 1, 0, be, mk_instr(1, 4'd3), 32'h0);
    chk(be ? "R4 wide store second" : "R5 wide store second", s_st, 32'hBBBB_0002);
  endtask

  task automatic t_float;
    logic [63:0] v;
    phase(1, 1, 0, 1, 0, mk_instr(0, 4'd7), 32'h0000_1234);
    phase(1, 1, 0, 0, 0, mk_instr(0, 4'd7), 32'h3F80_0000);
    chk("R6 float load done", {s_inc, s_done}, 2'b01);
    read_reg(4'd7, v);
    chk("R6 float load upper only", v, 64'h3F80_0000_0000_1234);
  endtask

  task automatic t_int;
    logic [63:0] v;
    phase(1, 1, 0, 1, 1, mk_instr(0, 4'd9), 32'h8000_0001);
    read_reg(4'd9, v);
    chk("R7 int load negative sign fill", v, 64'hFFFF_FFFF_8000_0001);
    phase(1, 1, 0, 1, 1, mk_instr(0, 4'd9), 32'h7000_0002);
    read_reg(4'd9, v);
    chk("R7 int load positive zero fill", v, 64'h0000_0000_7000_0002);
    phase(1, 1, 1, 1, 1, mk_instr(0, 4'd9), 32'h0);
    chk("R8 int store lower half", s_st, 32'h7000_0002);
  endtask

  task automatic t_index;
    logic [63:0] v;
    phase(1, 1, 0, 1, 0, mk_instr(0, 4'd2), 32'h0000_0042);
    read_reg(4'd2, v);
    chk("R9 target register written", v, 64'h0000_0000_0000_0042);
    read_reg(4'd15, v);
    chk("R9 other register untouched", v, 64'h0);
  endtask

  task automatic t_nondata;
    logic [63:0] v;
    phase(1, 0, 0, 1, 0, mk_instr(0, 4'd2), 32'hDEAD_BEEF);
    chk("R2 nondata DONE no INC", {s_inc, s_done}, 2'b01);
    read_reg(4'd2, v);
    chk("R2 nondata no write", v, 64'h0000_0000_0000_0042);
  endtask

  task automatic t_idle;
    logic [63:0] v;
    phase(0, 1, 0, 1, 0, mk_instr(0, 4'd2), 32'hCAFE_0000);
    chk("R10 idle no response", {s_inc, s_done}, 2'b00);
    chk("R10 idle st_word zero", s_st, 32'h0);
    phase(1, 1, 0, 1, 0, mk_instr(0, 4'd11), 32'hCAFE_0001);
    chk("R10 load beat st_word zero", s_st, 32'h0);
    read_reg(4'd2, v);
    chk("R10 idle no write", v, 64'h0000_0000_0000_0042);
  endtask

  task automatic t_restart;
    logic [63:0] v;
    phase(1, 1, 0, 0, 1, mk_instr(1, 4'd4), 32'h1234_5678);
    chk("R11 abandoned first beat INC", {s_inc, s_done}, 2'b10);
    phase(1, 0, 0, 0, 1, mk_instr(1, 4'd4), 32'h0);
    chk("R11 nondata mid transfer DONE", {s_inc, s_done}, 2'b01);
    phase(1, 1, 0, 0, 1, mk_instr(1, 4'd4), 32'h0000_00F1);
    chk("R11 restart first beat INC", {s_inc, s_done}, 2'b10);
    phase(1, 1, 0, 0, 1, mk_instr(1, 4'd4), 32'h0000_00F2);
    chk("R11 restart second beat DONE", {s_inc, s_done}, 2'b01);
    read_reg(4'd4, v);
    chk("R11 restart word placement", v, 64'h0000_00F1_0000_00F2);
  endtask

  initial begin : watchdog
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    phase_req = 0; phase_data = 0; xfer_store = 0; int_mode = 0; big_endian = 0;
    xfer_instr = '0; ld_word = '0;
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;
    t_reset;
    t_wide(1'b1);
    t_wide(1'b0);
    t_float;
    t_int;
    t_index;
    t_nondata;
    t_idle;
    t_restart;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule